// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block collects request lines from on-chip peripherals and presents them to a processor interrupt controller as one vector, with one bit per interrupt line. A line can be fed by a single peripheral source or by several sub-sources. Each line has a read-only identity word. That word shows which of the line's sub-sources is currently requesting, so a handler can find the cause without polling the peripherals. Every hardware source passes through a two-stage synchronizer first. The request vector toward the processor is then registered once more as the OR of the hardware lines and a software request register.

Software can raise or drop any line by writing 1s to the request register: a written 1 inverts the matching bit and a written 0 leaves it alone. One line, picked by a selector, can also drive a non-maskable interrupt output. The enable of that route is guarded by a three-byte key sequence. Any single write to the control word while the key is open uses up the unlock.

Top module: `irq_agg`

## Requirements
- R1: After reset, `irq_o` and `nmi_o` are 0, and the control, software-request and key-status words read 0.
- R2: Word address n (byte offset 4×n), for n below 32, reads the synchronized sub-source requests of line n in bits [k-1:0], where k is the line's source count, with all upper bits 0. Line 4 has 2 sources, line 5 has 3, and lines 6 and 7 have 4 each. Sources are packed into `src_i` line by line in ascending line order.
- R3: Lines with no source (16, 17, 20–24, 27, 30, 31) read 0 at their identity word and are raised at `irq_o` only by software.
- R4: Word 33 is the software request register. Writing 1 to a bit inverts it, writing 0 leaves it unchanged, and a read returns its current value.
- R5: `irq_o[n]` is the OR of line n's synchronized hardware sources and software request bit n. A rise on `src_i` shows at `irq_o` after exactly three rising clock edges. A software write shows one edge after the write edge.
- R6: Word 32 is the NMI control: bits [4:0] select a line and bit 8 is the enable. `nmi_o` equals `irq_o[select] & enable`.
- R7: While the key is locked, a write to word 32 updates the selector but leaves the enable unchanged.
- R8: Writing the low bytes 0x59, 0x16 and 0x88 in that order to word 34 opens the key. Any other byte during the sequence returns the key to locked. Word 34 reads 1 while the key is open and 0 otherwise.
- R9: A write to word 32 while the key is open updates the enable and locks the key again.
- R10: Read data appears on `rdata_o` one cycle after `rd_i` and is held until the next read. Word addresses 35 to 63 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC (31) | Asynchronous peripheral requests, packed by line |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NLINES (32) | Synchronized request vector to the interrupt controller |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Every cycle, the assertions check the following relations:
- `nmi_o` never rises without the enable.
- A locked control write never changes the enable.
- A zero write leaves the software register unchanged.
- Pending software requests always reach `irq_o`.
- Sourceless lines rise only from software.
- The key opens only on its final byte and closes after a control write.
- Read data holds between strobes.

Only the bench scenarios can show the rest:
- The exact three-edge latency from source to output.
- The packing of multi-source lines into identity words.
- The toggle semantics of the request register across several writes.
- A broken key sequence that falls back to locked.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int MAX_LINES = 32;
   localparam int CW        = 3;   // bits per line in the source-count map

   typedef enum logic [1:0] {K_IDLE, K_ONE, K_TWO, K_OPEN} key_st_e;

   function automatic logic [MAX_LINES*CW-1:0] def_map();
      logic [MAX_LINES*CW-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_LINES; i++) begin
         case (i)
            4:                                         m[i*CW +: CW] = 3'd2;
            5:                                         m[i*CW +: CW] = 3'd3;
            6, 7:                                      m[i*CW +: CW] = 3'd4;
            16, 17, 20, 21, 22, 23, 24, 27, 30, 31:    m[i*CW +: CW] = 3'd0;
            default:                                   m[i*CW +: CW] = 3'd1;
         endcase
      end
      return m;
   endfunction

   localparam logic [MAX_LINES*CW-1:0] DEF_MAP = def_map();

   function automatic int count_src(input logic [MAX_LINES*CW-1:0] m, input int upto);
      int s;
      s = 0;
      for (int i = 0; i < upto; i++) s += int'(m[i*CW +: CW]);
      return s;
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/irq_key_lock.sv
module irq_key_lock
   import irq_agg_pkg::*;
#(
   parameter logic [7:0] KEY0 = 8'h59,
   parameter logic [7:0] KEY1 = 8'h16,
   parameter logic [7:0] KEY2 = 8'h88
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       relock,
   output logic       open_o
);
   key_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (relock) begin
         st_d = K_IDLE;
      end else if (key_wr) begin
         case (st_q)
            K_IDLE:  st_d = (key_byte == KEY0) ? K_ONE  : K_IDLE;
            K_ONE:   st_d = (key_byte == KEY1) ? K_TWO  : K_IDLE;
            K_TWO:   st_d = (key_byte == KEY2) ? K_OPEN : K_IDLE;
            default: st_d = K_OPEN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= K_IDLE;
      else        st_q <= st_d;
   end

   assign open_o = (st_q == K_OPEN);

   // R8: the key opens only right after its last byte is written
   p_open_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(key_wr && key_byte == KEY2));

   // R9: a relock request always closes the key
   p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> !open_o);
endmodule

// File: rtl/irq_agg.sv
module irq_agg
   import irq_agg_pkg::*;
#(
   parameter int                         NLINES  = 32,
   parameter int                         ID_W    = 4,
   parameter int                         ADDR_W  = 6,
   parameter int                         SYNC_ST = 2,
   parameter logic [MAX_LINES*CW-1:0]    SRC_MAP = DEF_MAP,
   parameter int                         NSRC    = count_src(SRC_MAP, NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic [NLINES-1:0] irq_o,
   output logic              nmi_o
);
   localparam int SEL_W = $clog2(NLINES);
   localparam int EN_B  = 8;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(MAX_LINES);
   localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(MAX_LINES + 1);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(MAX_LINES + 2);

   if (NLINES > MAX_LINES || NLINES < 2) begin : g_bad_lines
      $error("NLINES out of range");
   end
   if (ID_W > 32 || ID_W < 1) begin : g_bad_idw
      $error("ID_W out of range");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("at least one source is needed");
   end

   logic [NSRC-1:0]   src_s;
   logic [ID_W-1:0]   ident [NLINES];
   logic [NLINES-1:0] hw_line;
   logic [NLINES-1:0] swreq_q;
   logic [SEL_W-1:0]  sel_q;
   logic              en_q;
   logic              unlocked;
   logic [31:0]       rd_mux;

   wire wr_ctrl = wr_i && (addr_i == A_CTRL);
   wire wr_sw   = wr_i && (addr_i == A_SW);
   wire wr_key  = wr_i && (addr_i == A_KEY);

   irq_sync #(.W(NSRC), .STAGES(SYNC_ST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_i), .q(src_s)
   );

   irq_key_lock u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_byte(wdata_i[7:0]),
      .relock(wr_ctrl && unlocked), .open_o(unlocked)
   );

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      localparam int CNT  = int'(SRC_MAP[g*CW +: CW]);
      localparam int BASE = count_src(SRC_MAP, g);
      if (CNT > ID_W) begin : g_bad_cnt
         $error("line source count exceeds ID_W");
      end
      if (CNT == 0) begin : g_rsv
         assign ident[g] = '0;
         // R3: a sourceless line rises only from a software request
         p_rsv_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |-> $past(swreq_q[g]));
      end else begin : g_used
         assign ident[g] = ID_W'(src_s[BASE +: CNT]);
      end
      assign hw_line[g] = |ident[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         en_q    <= 1'b0;
         swreq_q <= '0;
         irq_o   <= '0;
      end else begin
         if (wr_ctrl) begin
            sel_q <= wdata_i[SEL_W-1:0];
            if (unlocked) en_q <= wdata_i[EN_B];
         end
         if (wr_sw) swreq_q <= swreq_q ^ wdata_i[NLINES-1:0];
         irq_o <= hw_line | swreq_q;
      end
   end

   assign nmi_o = en_q && (32'(sel_q) < NLINES) && irq_o[sel_q];

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NLINES; i++) begin
         if (addr_i == ADDR_W'(i)) rd_mux = 32'(ident[i]);
      end
      if (addr_i == A_CTRL) rd_mux = 32'(sel_q) | (32'(en_q) << EN_B);
      if (addr_i == A_SW)   rd_mux = 32'(swreq_q);
      if (addr_i == A_KEY)  rd_mux = 32'(unlocked);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_mux;
   end

   // R6: no NMI without the enable
   p_nmi_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !nmi_o);
   // R7: a locked control write cannot move the enable
   p_en_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !unlocked) |=> $stable(en_q));
   // R4: a zero write leaves the request register unchanged
   p_sw_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sw && wdata_i == '0) |=> $stable(swreq_q));
   // R5: a pending software request always reaches the output
   p_sw_reach_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|swreq_q) |=> (|irq_o));
   // R10: read data holds between read strobes
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
   localparam int NL = 32;
   localparam int NS = 31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NL-1:0] irq;
   logic        nmi;

   int total = 0, bad = 0;
   bit done = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_agg dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_i(wr), .rd_i(rd),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .nmi_o(nmi)
   );

   function automatic int cnt(int n);
      case (n)
         4: return 2;
         5: return 3;
         6, 7: return 4;
         16, 17, 20, 21, 22, 23, 24, 27, 30, 31: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int base(int n);
      int s = 0;
      for (int i = 0; i < n; i++) s += cnt(i);
      return s;
   endfunction

   function automatic logic [31:0] exp_id(logic [NS-1:0] s, int n);
      logic [31:0] v = '0;
      for (int k = 0; k < cnt(n); k++) v[k] = s[base(n) + k];
      return v;
   endfunction

   function automatic logic [NL-1:0] exp_irq(logic [NS-1:0] s, logic [NL-1:0] sw);
      logic [NL-1:0] v = sw;
      for (int n = 0; n < NL; n++) if (exp_id(s, n) != 0) v[n] = 1'b1;
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(logic [5:0] a, logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(logic [5:0] a, logic [31:0] e, string tag);
      @(negedge clk); rd = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); rd = 1'b0;
   endtask

   // scoreboard monitor
   always @(posedge clk) rd_seen <= rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) chk("monitor underflow", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [NS-1:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq reset", 32'(irq), 0);
      chk("R1 nmi reset", 32'(nmi), 0);
      rd_reg(6'd32, 0, "R1 ctrl reset");
      rd_reg(6'd33, 0, "R1 sw reset");
      rd_reg(6'd34, 0, "R1 key reset");

      // R5 latency of exactly three edges
      @(negedge clk); src[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R5 not yet after two edges", 32'(irq[0]), 0);
      @(negedge clk);
      chk("R5 after three edges", 32'(irq[0]), 1);

      // R2 merged lines
      s = '0;
      s[base(5) +: 3] = 3'b101;
      s[base(6) +: 4] = 4'b1010;
      s[base(4) +: 2] = 2'b10;
      src = s;
      repeat (4) @(negedge clk);
      rd_reg(6'd5, 32'h5, "R2 three-source line");
      rd_reg(6'd6, 32'hA, "R2 four-source line");
      rd_reg(6'd4, 32'h2, "R2 two-source line");
      rd_reg(6'd7, exp_id(s, 7), "R2 idle line");
      chk("R5 hw OR", 32'(irq), 32'(exp_irq(s, '0)));

      // R3 reserved lines with every source high
      s = '1; src = s;
      repeat (4) @(negedge clk);
      rd_reg(6'd16, 0, "R3 reserved 16");
      rd_reg(6'd27, 0, "R3 reserved 27");
      rd_reg(6'd6, 32'hF, "R2 all four sources");
      chk("R3 reserved bits low", 32'(irq), 32'(exp_irq(s, '0)));

      // R4 software toggle
      src = '0;
      repeat (4) @(negedge clk);
      wr_reg(6'd33, 32'h0001_0000);
      @(negedge clk);
      chk("R5 sw line 16", 32'(irq), 32'h0001_0000);
      rd_reg(6'd33, 32'h0001_0000, "R4 set");
      wr_reg(6'd33, 32'h0);
      rd_reg(6'd33, 32'h0001_0000, "R4 zero write");
      wr_reg(6'd33, 32'h0001_0008);
      rd_reg(6'd33, 32'h0000_0008, "R4 toggle");

      // R7 locked enable
      wr_reg(6'd32, 32'h110);
      rd_reg(6'd32, 32'h010, "R7 enable ignored");
      chk("R7 nmi off", 32'(nmi), 0);
      wr_reg(6'd33, 32'h0001_0000);

      // R8/R9 unlock then relock
      wr_reg(6'd34, 32'h59); wr_reg(6'd34, 32'h16); wr_reg(6'd34, 32'h88);
      rd_reg(6'd34, 1, "R8 open");
      wr_reg(6'd32, 32'h110);
      rd_reg(6'd34, 0, "R9 relocked");
      rd_reg(6'd32, 32'h110, "R9 enable written");
      chk("R6 nmi from line 16", 32'(nmi), 1);
      wr_reg(6'd32, 32'h103);
      chk("R6 nmi from line 3", 32'(nmi), 1);
      wr_reg(6'd33, 32'h8);
      @(negedge clk);
      chk("R6 nmi follows line", 32'(nmi), 0);

      // R8 broken sequence
      wr_reg(6'd34, 32'h59); wr_reg(6'd34, 32'h88);
      wr_reg(6'd34, 32'h16); wr_reg(6'd34, 32'h88);
      rd_reg(6'd34, 0, "R8 wrong order");
      wr_reg(6'd34, 32'h59); wr_reg(6'd34, 32'h16); wr_reg(6'd34, 32'h88);
      wr_reg(6'd32, 32'h003);
      rd_reg(6'd32, 32'h003, "R9 enable cleared");

      // R10 undefined words
      rd_reg(6'd35, 0, "R10 word 35");
      rd_reg(6'd63, 0, "R10 word 63");

      repeat (3) @(negedge clk);
      summary();
   end
endmodule